// File: doc/BRIEF.md
# Single-Wire EEPROM Read Controller

This block is the read-side state machine of a small serial EEPROM slave. It works at byte and transaction level: a front end that handles the line timing presents start, stop, received-byte and master-acknowledge events as one-cycle pulses. The controller answers with the slave acknowledge decision and with the next byte to shift out.

It decodes the device header byte and accepts a dummy write that loads the shared address pointer. It then serves current-address, random and sequential reads from three spaces: a 128-byte main array, a 32-byte security area and a fixed 24-bit identification value. Both memory spaces share one pointer, but each wraps at its own size. The identification value has its own three-byte pointer. The arrays are plain registers filled through a simple load port, for example by a testbench or by a boot loader.

Top module: `serial_mem_read_ctrl`

## Requirements
- R1: A header byte is decoded as opcode in bits [7:4], slave address in bits [3:1] and direction in bit [0] (1 = read). Opcode 4'hA selects the main array, 4'hB the security area and 4'hC the identification value. An accepted header gives `sAckValid`=1 with `sAckBit`=0 one cycle after its `byteValid` pulse.
- R2: A header whose slave address differs from `strapAddr`, or whose opcode is not one of the three above, is answered with `sAckBit`=1. Later bytes and master acknowledges produce no output until the next start.
- R3: A main write header followed by one address byte gets an ACK for each byte. The pointer is loaded from address bits [6:0], and bit 7 is ignored. After a restart and a main read header, the first data byte is the main array entry at that address. It appears together with the header ACK.
- R4: A master acknowledge of 0 during a read gives the next byte one cycle later, with the pointer advanced. In the main array the pointer wraps from 127 to 0.
- R5: A master acknowledge of 1 ends the read with no further data. A later main read without a dummy write starts at the entry after the last byte sent.
- R6: A security dummy write uses only address bits [4:0]. Sequential security reads wrap from 31 to 0.
- R7: A security read header is NACKed unless a security dummy write came earlier in the same transaction. A stop, or a start made anywhere other than straight after the address byte, ends the transaction.
- R8: An identification read header is ACKed. It returns the 24-bit value as three bytes, bits 23:16 first, then 15:8, then 7:0. An ACK after the third byte returns to the first, and every new header starts at the first byte.
- R9: An identification header with direction 0 is NACKed, and the bytes that follow produce no output.
- R10: A stop, or an unexpected start, during a read stops all output. The pointer keeps its value for the next current-address read.
- R11: After reset, no acknowledge or data is valid and the pointer is 0.
- R12: While `ldEn` is high, `ldData` is written to the main array (`ldSec`=0) or to the security area (`ldSec`=1) at `ldAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strapAddr | input | 3 | Strapped slave address |
| startEv | input | 1 | Start or repeated start seen |
| stopEv | input | 1 | Stop seen |
| byteValid | input | 1 | Byte from the master is valid |
| byteIn | input | 8 | Received byte |
| mAckValid | input | 1 | Master acknowledge bit is valid |
| mAckBit | input | 1 | Master acknowledge, 0 = more data, 1 = end |
| ldEn | input | 1 | Load strobe for storage |
| ldSec | input | 1 | Load target, 1 = security area |
| ldAddr | input | MAIN_AW | Load address |
| ldData | input | 8 | Load data |
| sAckValid | output | 1 | Slave acknowledge decision valid |
| sAckBit | output | 1 | Slave acknowledge, 0 = ACK, 1 = NACK |
| dataValid | output | 1 | Next data byte valid |
| dataOut | output | 8 | Next data byte to shift out |

## Verification
Every slave acknowledge and every data byte is registered, so it is due exactly one clock after the byte or acknowledge pulse that causes it. A read header ACK and its first data byte arrive in the same cycle. The driver records each expected item together with that due cycle. The monitor compares on the falling edge, and an item that comes early or late fails just as a wrong value does. Where a stimulus must have no effect, both outputs are sampled in the cycle after it. A later current-address read then shows that the pointer did not move.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;
  localparam logic [3:0] OP_MAIN = 4'hA;
  localparam logic [3:0] OP_SEC  = 4'hB;
  localparam logic [3:0] OP_ID   = 4'hC;

  typedef enum logic [1:0] {SP_MAIN, SP_SEC, SP_ID} space_e;
  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_ADDR, ST_RSTRT, ST_READ} state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadPtr;
    logic [7:0] loadAddr;
    space_e     loadSpace;
    logic       emit;
    space_e     emitSpace;
    logic       idFirst;
  } strobe_t;
endpackage

// File: rtl/serial_mem_ctrl.sv
module serial_mem_ctrl
  import serial_mem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strapAddr,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  logic       mAckValid,
  input  logic       mAckBit,
  output strobe_t    strb,
  output logic       sAckValid,
  output logic       sAckBit,
  output logic       dataValid
);
  state_e state, stateN;
  space_e addrSpace, addrSpaceN, readSpace, readSpaceN;
  logic   secArmed, secArmedN;
  logic   ackV, ackB;

  logic [3:0] hdrOp;
  logic       hdrRead, hdrHit;
  assign hdrOp   = byteIn[7:4];
  assign hdrRead = byteIn[0];
  assign hdrHit  = (byteIn[3:1] == strapAddr);

  always_comb begin
    stateN     = state;
    secArmedN  = secArmed;
    addrSpaceN = addrSpace;
    readSpaceN = readSpace;
    ackV       = 1'b0;
    ackB       = 1'b0;
    strb       = '0;
    if (stopEv) begin
      stateN    = ST_IDLE;
      secArmedN = 1'b0;
    end else if (startEv) begin
      stateN    = ST_HDR;
      secArmedN = secArmed && (state == ST_RSTRT);
    end else if (byteValid) begin
      unique case (state)
        ST_HDR: begin
          ackV   = 1'b1;
          ackB   = 1'b1;
          stateN = ST_IDLE;
          if (hdrHit) begin
            if (!hdrRead && (hdrOp == OP_MAIN || hdrOp == OP_SEC)) begin
              ackB       = 1'b0;
              stateN     = ST_ADDR;
              addrSpaceN = (hdrOp == OP_SEC) ? SP_SEC : SP_MAIN;
            end else if (hdrRead && (hdrOp == OP_MAIN ||
                                     (hdrOp == OP_SEC && secArmed) ||
                                     hdrOp == OP_ID)) begin
              ackB           = 1'b0;
              stateN         = ST_READ;
              readSpaceN     = (hdrOp == OP_MAIN) ? SP_MAIN :
                               (hdrOp == OP_SEC)  ? SP_SEC  : SP_ID;
              strb.emit      = 1'b1;
              strb.emitSpace = readSpaceN;
              strb.idFirst   = (hdrOp == OP_ID);
            end
          end
        end
        ST_ADDR: begin
          ackV           = 1'b1;
          ackB           = 1'b0;
          strb.loadPtr   = 1'b1;
          strb.loadAddr  = byteIn;
          strb.loadSpace = addrSpace;
          secArmedN      = (addrSpace == SP_SEC);
          stateN         = ST_RSTRT;
        end
        default: ;
      endcase
    end else if (mAckValid && state == ST_READ) begin
      if (!mAckBit) begin
        strb.emit      = 1'b1;
        strb.emitSpace = readSpace;
      end else begin
        stateN = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addrSpace <= SP_MAIN;
      readSpace <= SP_MAIN;
      secArmed  <= 1'b0;
      sAckValid <= 1'b0;
      sAckBit   <= 1'b0;
      dataValid <= 1'b0;
    end else begin
      state     <= stateN;
      addrSpace <= addrSpaceN;
      readSpace <= readSpaceN;
      secArmed  <= secArmedN;
      sAckValid <= ackV;
      sAckBit   <= ackB;
      dataValid <= strb.emit;
    end
  end
endmodule

// File: rtl/serial_mem_dp.sv
module serial_mem_dp
  import serial_mem_pkg::*;
#(
  parameter int          MAIN_DEPTH = 128,
  parameter int          SEC_DEPTH  = 32,
  parameter logic [23:0] ID_VALUE   = 24'h00D200,
  localparam int         MAIN_AW    = $clog2(MAIN_DEPTH),
  localparam int         SEC_AW     = $clog2(SEC_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strb,
  input  logic               ldEn,
  input  logic               ldSec,
  input  logic [MAIN_AW-1:0] ldAddr,
  input  logic [7:0]         ldData,
  output logic [7:0]         dataOut
);
  localparam int PTR_W = (MAIN_AW > SEC_AW) ? MAIN_AW : SEC_AW;

  logic [7:0]       mainMem [MAIN_DEPTH];
  logic [7:0]       secMem  [SEC_DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [1:0]       idPtr;

  logic [SEC_AW-1:0]  secIdx, secNext;
  logic [MAIN_AW-1:0] mainIdx;
  logic [1:0]         idSel;
  logic [23:0]        idShift;

  assign secIdx  = SEC_AW'(ptr);
  assign secNext = secIdx + 1'b1;
  assign mainIdx = MAIN_AW'(ptr);
  assign idSel   = strb.idFirst ? 2'd0 : idPtr;
  assign idShift = ID_VALUE << {idSel, 3'b000};

  always_ff @(posedge clk) begin
    if (ldEn) begin
      if (ldSec) secMem[SEC_AW'(ldAddr)] <= ldData;
      else       mainMem[ldAddr]         <= ldData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      idPtr   <= '0;
      dataOut <= '0;
    end else if (strb.loadPtr) begin
      if (strb.loadSpace == SP_SEC) ptr <= PTR_W'(SEC_AW'(strb.loadAddr));
      else                          ptr <= PTR_W'(MAIN_AW'(strb.loadAddr));
    end else if (strb.emit) begin
      unique case (strb.emitSpace)
        SP_SEC: begin
          dataOut <= secMem[secIdx];
          ptr     <= PTR_W'(secNext);
        end
        SP_ID: begin
          dataOut <= idShift[23:16];
          idPtr   <= (idSel == 2'd2) ? 2'd0 : idSel + 2'd1;
        end
        default: begin
          dataOut <= mainMem[mainIdx];
          ptr     <= PTR_W'(mainIdx + 1'b1);
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_mem_read_ctrl.sv
module serial_mem_read_ctrl
  import serial_mem_pkg::*;
#(
  parameter int          MAIN_DEPTH = 128,
  parameter int          SEC_DEPTH  = 32,
  parameter logic [23:0] ID_VALUE   = 24'h00D200,
  localparam int         MAIN_AW    = $clog2(MAIN_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         strapAddr,
  input  logic               startEv,
  input  logic               stopEv,
  input  logic               byteValid,
  input  logic [7:0]         byteIn,
  input  logic               mAckValid,
  input  logic               mAckBit,
  input  logic               ldEn,
  input  logic               ldSec,
  input  logic [MAIN_AW-1:0] ldAddr,
  input  logic [7:0]         ldData,
  output logic               sAckValid,
  output logic               sAckBit,
  output logic               dataValid,
  output logic [7:0]         dataOut
);
  strobe_t strb;

  serial_mem_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .strapAddr(strapAddr),
    .startEv(startEv), .stopEv(stopEv),
    .byteValid(byteValid), .byteIn(byteIn),
    .mAckValid(mAckValid), .mAckBit(mAckBit),
    .strb(strb), .sAckValid(sAckValid), .sAckBit(sAckBit),
    .dataValid(dataValid)
  );

  serial_mem_dp #(
    .MAIN_DEPTH(MAIN_DEPTH), .SEC_DEPTH(SEC_DEPTH), .ID_VALUE(ID_VALUE)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .ldEn(ldEn), .ldSec(ldSec), .ldAddr(ldAddr), .ldData(ldData),
    .dataOut(dataOut)
  );
endmodule

// File: rtl/serial_mem_read_ctrl_chk.sv
module serial_mem_read_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic startEv,
  input logic stopEv,
  input logic byteValid,
  input logic mAckValid,
  input logic mAckBit,
  input logic sAckValid,
  input logic sAckBit,
  input logic dataValid
);
  a_r1_ack_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    sAckValid |-> $past(byteValid));

  a_r4_data_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> ($past(byteValid) || $past(mAckValid)));

  a_r2_nack_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (sAckValid && sAckBit) |-> !dataValid);

  a_r5_nack_ends_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mAckValid && mAckBit && !byteValid && !startEv && !stopEv) |=> !dataValid);

  a_r10_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
    stopEv |=> (!dataValid && !sAckValid));

  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!dataValid && !sAckValid));
endmodule

bind serial_mem_read_ctrl serial_mem_read_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .startEv(startEv), .stopEv(stopEv),
  .byteValid(byteValid), .mAckValid(mAckValid), .mAckBit(mAckBit),
  .sAckValid(sAckValid), .sAckBit(sAckBit), .dataValid(dataValid)
);

// File: tb/serial_mem_read_ctrl_tb_top.sv
module serial_mem_read_ctrl_tb_top;
  localparam int          MAIN_DEPTH = 128;
  localparam int          SEC_DEPTH  = 32;
  localparam int          MAIN_AW    = 7;
  localparam logic [23:0] IDV        = 24'h3CD381;
  localparam logic [2:0]  STRAP      = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic startEv = 0, stopEv = 0, byteValid = 0, mAckValid = 0, mAckBit = 0;
  logic [7:0] byteIn = '0;
  logic ldEn = 0, ldSec = 0;
  logic [MAIN_AW-1:0] ldAddr = '0;
  logic [7:0] ldData = '0;
  logic sAckValid, sAckBit, dataValid;
  logic [7:0] dataOut;

  always #5 clk = ~clk;

  serial_mem_read_ctrl #(.MAIN_DEPTH(MAIN_DEPTH), .SEC_DEPTH(SEC_DEPTH), .ID_VALUE(IDV)) dut_i (
    .clk(clk), .rst_n(rst_n), .strapAddr(STRAP),
    .startEv(startEv), .stopEv(stopEv), .byteValid(byteValid), .byteIn(byteIn),
    .mAckValid(mAckValid), .mAckBit(mAckBit),
    .ldEn(ldEn), .ldSec(ldSec), .ldAddr(ldAddr), .ldData(ldData),
    .sAckValid(sAckValid), .sAckBit(sAckBit), .dataValid(dataValid), .dataOut(dataOut));

  typedef struct {bit isData; logic [7:0] val; int due; string tag;} item_t;
  item_t expQ[$];
  int cyc = 0, nChecks = 0, nFails = 0;
  bit done = 0;
  logic [7:0] mainModel [MAIN_DEPTH];
  logic [7:0] secModel  [SEC_DEPTH];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] hdr(input logic [3:0] op, input logic rw);
    return {op, STRAP, rw};
  endfunction

  task automatic report(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // monitor: compares outputs against queued expectations in their due cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sAckValid) begin
        if (expQ.size() == 0 || expQ[0].isData) report(0, "unexpected ack", {7'b0, sAckBit}, 8'hFF);
        else begin
          report(expQ[0].due == cyc && expQ[0].val[0] == sAckBit, expQ[0].tag, {7'b0, sAckBit}, expQ[0].val);
          void'(expQ.pop_front());
        end
      end
      if (dataValid) begin
        if (expQ.size() == 0 || !expQ[0].isData) report(0, "unexpected data", dataOut, 8'hFF);
        else begin
          report(expQ[0].due == cyc && expQ[0].val == dataOut, expQ[0].tag, dataOut, expQ[0].val);
          void'(expQ.pop_front());
        end
      end
      while (expQ.size() > 0 && expQ[0].due <= cyc) begin
        report(0, {expQ[0].tag, " missing"}, 8'h00, expQ[0].val);
        void'(expQ.pop_front());
      end
    end
  end

  task automatic expAck(input logic b, input string tag);
    expQ.push_back('{1'b0, {7'b0, b}, cyc + 1, tag});
  endtask
  task automatic expData(input logic [7:0] v, input string tag);
    expQ.push_back('{1'b1, v, cyc + 1, tag});
  endtask

  task automatic pulse(input bit s, input bit p, input bit bv, input logic [7:0] b, input bit mv, input bit mb);
    startEv = s; stopEv = p; byteValid = bv; byteIn = b; mAckValid = mv; mAckBit = mb;
    @(negedge clk);
    startEv = 0; stopEv = 0; byteValid = 0; mAckValid = 0; mAckBit = 0;
  endtask
  task automatic doStart(); pulse(1, 0, 0, 8'h00, 0, 0); endtask
  task automatic doStop();  pulse(0, 1, 0, 8'h00, 0, 0); endtask
  task automatic sendByte(input logic [7:0] b); pulse(0, 0, 1, b, 0, 0); endtask
  task automatic mAck(input bit b); pulse(0, 0, 0, 8'h00, 1, b); endtask

  // outputs sampled in the cycle after a stimulus that must have no effect
  task automatic checkQuiet(input string tag);
    report(!sAckValid && !dataValid, tag, {6'b0, sAckValid, dataValid}, 8'h00);
  endtask

  task automatic dummyWrite(input logic [3:0] op, input logic [7:0] a, input string tag);
    doStart();
    expAck(1'b0, tag); sendByte(hdr(op, 1'b0));
    expAck(1'b0, tag); sendByte(a);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MAIN_DEPTH; i++) mainModel[i] = 8'(i * 37 + 11);
    for (int i = 0; i < SEC_DEPTH; i++)  secModel[i]  = 8'hA0 ^ 8'(i * 5);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checkQuiet("R11 reset outputs idle");
    // R12 preload through load port
    for (int i = 0; i < MAIN_DEPTH; i++) begin
      ldEn = 1; ldSec = 0; ldAddr = MAIN_AW'(i); ldData = mainModel[i]; @(negedge clk);
    end
    for (int i = 0; i < SEC_DEPTH; i++) begin
      ldEn = 1; ldSec = 1; ldAddr = MAIN_AW'(i); ldData = secModel[i]; @(negedge clk);
    end
    ldEn = 0;

    // R11: pointer starts at 0
    doStart();
    expAck(1'b0, "R11 main read hdr"); expData(mainModel[0], "R11 R12 first byte at 0");
    sendByte(hdr(4'hA, 1'b1));
    mAck(1'b1); checkQuiet("R5 nack ends read");
    doStop();

    // R3 random read, bit 7 ignored; R4 sequential
    dummyWrite(4'hA, 8'hA5, "R3 dummy write ack");
    doStart();
    expAck(1'b0, "R3 read hdr"); expData(mainModel[8'h25], "R3 random data");
    sendByte(hdr(4'hA, 1'b1));
    expData(mainModel[8'h26], "R4 sequential next"); mAck(1'b0);
    mAck(1'b1); doStop();

    // R5 current address continues
    doStart();
    expAck(1'b0, "R5 hdr"); expData(mainModel[8'h27], "R5 current address");
    sendByte(hdr(4'hA, 1'b1));
    mAck(1'b1); doStop();

    // R4 wrap in main array
    dummyWrite(4'hA, 8'h7E, "R4 dummy write");
    doStart();
    expAck(1'b0, "R4 hdr"); expData(mainModel[126], "R4 byte 126");
    sendByte(hdr(4'hA, 1'b1));
    expData(mainModel[127], "R4 byte 127"); mAck(1'b0);
    expData(mainModel[0], "R4 wrap to 0"); mAck(1'b0);
    mAck(1'b1); doStop();

    // R6 security space, bits [4:0], wrap 31->0
    dummyWrite(4'hB, 8'hFE, "R6 sec dummy write");
    doStart();
    expAck(1'b0, "R6 sec hdr"); expData(secModel[30], "R6 sec byte 30");
    sendByte(hdr(4'hB, 1'b1));
    expData(secModel[31], "R6 sec byte 31"); mAck(1'b0);
    expData(secModel[0], "R6 sec wrap to 0"); mAck(1'b0);
    mAck(1'b1); doStop();

    // R7 security read without arming
    doStart();
    expAck(1'b1, "R7 unarmed sec read nack"); sendByte(hdr(4'hB, 1'b1));
    sendByte(8'h00); checkQuiet("R2 bytes ignored after nack");
    doStop();
    dummyWrite(4'hA, 8'h40, "R7 main dummy write");
    doStart();
    expAck(1'b1, "R7 sec read after main dummy nack"); sendByte(hdr(4'hB, 1'b1));
    doStop();

    // R8 identification read
    doStart();
    expAck(1'b0, "R8 id hdr"); expData(IDV[23:16], "R8 id byte hi");
    sendByte(hdr(4'hC, 1'b1));
    expData(IDV[15:8], "R8 id byte mid"); mAck(1'b0);
    expData(IDV[7:0], "R8 id byte lo"); mAck(1'b0);
    expData(IDV[23:16], "R8 id wrap"); mAck(1'b0);
    expData(IDV[15:8], "R8 id after wrap"); mAck(1'b0);
    mAck(1'b1); doStop();
    doStart();
    expAck(1'b0, "R8 id hdr again"); expData(IDV[23:16], "R8 id restarts at first");
    sendByte(hdr(4'hC, 1'b1));
    mAck(1'b1); doStop();

    // R9 identification write refused
    doStart();
    expAck(1'b1, "R9 id write nack"); sendByte(hdr(4'hC, 1'b0));
    sendByte(8'h12); checkQuiet("R9 byte after id write ignored");
    doStop();

    // R2 bad slave address and bad opcode
    doStart();
    expAck(1'b1, "R2 wrong slave nack"); sendByte({4'hA, 3'b010, 1'b1});
    mAck(1'b0); checkQuiet("R2 master ack ignored");
    doStart();
    expAck(1'b1, "R2 bad opcode nack"); sendByte(hdr(4'hE, 1'b1));
    doStop();

    // R10 abort by start and by stop, pointer kept
    dummyWrite(4'hA, 8'h10, "R10 dummy write");
    doStart();
    expAck(1'b0, "R10 hdr"); expData(mainModel[8'h10], "R10 data 0x10");
    sendByte(hdr(4'hA, 1'b1));
    doStart(); checkQuiet("R10 start aborts");
    mAck(1'b0); checkQuiet("R10 no data after abort");
    doStop();
    doStart();
    expAck(1'b0, "R10 hdr2"); expData(mainModel[8'h11], "R10 pointer kept");
    sendByte(hdr(4'hA, 1'b1));
    expData(mainModel[8'h12], "R10 seq"); mAck(1'b0);
    doStop(); checkQuiet("R10 stop aborts");
    mAck(1'b0); checkQuiet("R10 ack after stop ignored");
    doStart();
    expAck(1'b0, "R10 hdr3"); expData(mainModel[8'h13], "R10 pointer kept after stop");
    sendByte(hdr(4'hA, 1'b1));
    mAck(1'b1); doStop();

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) report(0, "leftover expectations", 8'(expQ.size()), 8'h00);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule